// File: doc/BRIEF.md
# Skewed Interleaved Memory Vector Adder

The block forms C = A + B, element by element, over 8-element vectors that live in eight independent memory modules. Each module holds one element of A, one element of B and one element of C. The three vectors are spread across the modules with a different rotation per vector: A starts in module 0, B is rotated by two modules, and C is rotated by four. Each module access occupies its module for two clocks. A timetable controller issues every read and every write on a fixed clock, so that no module is asked for a second access while it is busy. A four-stage pipelined adder sits between the reads and the writes and accepts one operand pair per clock.

The caller presents the A and B contents of every module as static images and pulses `start_i`. Clock 0 of a run is the first clock after the edge that samples the start. The reads of element i start in clock i. Operand i reaches the adder in clock i+2, and its sum leaves the adder at the end of clock i+5. The write of C_i starts in clock i+6 and takes two clocks. The controller has three states. ST_IDLE goes to ST_RUN on start. ST_RUN steps a clock counter from 0 to 14 and then goes to ST_DONE. ST_DONE holds the done flag and goes back to ST_RUN on the next start. Every module reports an access that overlaps a busy period or that mixes a read and a write in one clock. These reports set a sticky error flag, which is cleared when a new run is accepted.

Top module: `skew_vec_adder`

## Requirements
- R1: While reset is held, `done_o` and `clash_o` are 0 and every result slot in `res_o` is 0.
- R2: The bench places element i of A in `img_a_i` word i and element i of B in `img_b_i` word (i+2) mod 8. The result C_i = A_i + B_i is then found in `res_o` word (i+4) mod 8.
- R3: Each sum is taken modulo 2^W. A carry runs through every bit position, including across the 8-bit segments of the pipeline stages, and a carry out of the top bit is dropped.
- R4: If the start is sampled at edge E, C_i becomes visible in its `res_o` word in clock i+8 after E and not before. `done_o` is 0 in clock 14 and rises in clock 15.
- R5: A full run under the fixed timetable never raises `clash_o`.
- R6: A start pulse that arrives while a run is in progress has no effect: `done_o` still rises in clock 15 of the original run, and the results are unchanged.
- R7: `done_o` stays high in ST_DONE until the next start is accepted, and it is 0 in clock 0 of the new run.
- R8: A new run started from ST_DONE overwrites all eight result slots with the sums of the current images.
- R9: A module captures its operand from the image at the end of the second clock of its read. For element i that is the end of clock i+1. A change to the image after that point does not affect C_i, and a change before it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted in ST_IDLE or ST_DONE |
| img_a_i | input | NB*W | A word held by each module; word m belongs to module m |
| img_b_i | input | NB*W | B word held by each module; word m belongs to module m |
| res_o | output | NB*W | C slot of each module; word m belongs to module m |
| done_o | output | 1 | High in ST_DONE |
| clash_o | output | 1 | Sticky flag for an overlapping module access |

## Verification
Reads and writes run side by side in different modules. In clock 6, module 4 opens the write of C0 while module 0 opens the read of B6. Through clock 9, writes of C0..C3 interleave with the reads of A7 and B7. Every run exercises this overlap, and the bench judges it by the eight result words, by the exact clock in which C0 and done appear, and by a clash flag that stays low. Two further cases share clocks in the same way. A start arriving mid-run lands on the timetable, and the result must not move. An image rewrite lands between the capture of A0 and the read of A7, and C0 must keep the old operand while C7 takes the new one.

// File: rtl/vsk_pkg.sv
package vsk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sched_state_e;

endpackage

// File: rtl/vsk_bank.sv
module vsk_bank #(
    parameter int W   = 32,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_req_i,
    input  logic         rd_selb_i,
    input  logic         wr_req_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] img_a_i,
    input  logic [W-1:0] img_b_i,
    output logic [W-1:0] rd_data_o,
    output logic [W-1:0] res_o,
    output logic         clash_o
);

    localparam int RW = $clog2(LAT + 1);

    logic [RW-1:0] rem;
    logic          op_wr;
    logic          selb;
    logic [W-1:0]  wd;
    logic          any_req;

    assign any_req = rd_req_i || wr_req_i;
    assign clash_o = any_req && ((rem != '0) || (rd_req_i && wr_req_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem       <= '0;
            op_wr     <= 1'b0;
            selb      <= 1'b0;
            wd        <= '0;
            rd_data_o <= '0;
            res_o     <= '0;
        end else if (any_req) begin
            rem   <= RW'(LAT - 1);
            op_wr <= wr_req_i;
            selb  <= rd_selb_i;
            wd    <= wr_data_i;
        end else if (rem != '0) begin
            rem <= rem - 1'b1;
            if (rem == RW'(1)) begin
                if (op_wr) begin
                    res_o <= wd;
                end else begin
                    rd_data_o <= selb ? img_b_i : img_a_i;
                end
            end
        end
    end

    // R5: a module is never addressed while an access is still open
    p_free_on_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> (rem == '0));

    // R5: read and write never meet in one module in one clock
    p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_i && wr_req_i));

    // R9: read data moves only when an access completes
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rem == '0) |=> $stable(rd_data_o));

endmodule

// File: rtl/vsk_padd.sv
module vsk_padd #(
    parameter int W      = 32,
    parameter int STAGES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         vld_o,
    output logic [W-1:0] sum_o
);

    localparam int CW = W / STAGES;

    logic [W-1:0] pa [STAGES];
    logic [W-1:0] pb [STAGES];
    logic [W-1:0] ps [STAGES+1];
    logic         pc [STAGES];
    logic         pv [STAGES+1];

    assign pa[0] = a_i;
    assign pb[0] = b_i;
    assign ps[0] = '0;
    assign pc[0] = 1'b0;
    assign pv[0] = vld_i;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s < STAGES - 1) begin : g_mid
            logic [CW:0] part;
            assign part = {1'b0, pa[s][s*CW +: CW]} + {1'b0, pb[s][s*CW +: CW]}
                        + (CW+1)'(pc[s]);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pa[s+1] <= '0;
                    pb[s+1] <= '0;
                    ps[s+1] <= '0;
                    pc[s+1] <= 1'b0;
                    pv[s+1] <= 1'b0;
                end else begin
                    pa[s+1] <= pa[s];
                    pb[s+1] <= pb[s];
                    ps[s+1] <= ps[s];
                    ps[s+1][s*CW +: CW] <= part[CW-1:0];
                    pc[s+1] <= part[CW];
                    pv[s+1] <= pv[s];
                end
            end
        end else begin : g_last
            logic [CW-1:0] part;
            assign part = pa[s][s*CW +: CW] + pb[s][s*CW +: CW] + CW'(pc[s]);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ps[s+1] <= '0;
                    pv[s+1] <= 1'b0;
                end else begin
                    ps[s+1] <= ps[s];
                    ps[s+1][s*CW +: CW] <= part;
                    pv[s+1] <= pv[s];
                end
            end
        end
    end

    assign sum_o = ps[STAGES];
    assign vld_o = pv[STAGES];

    if (STAGES == 4) begin : g_chk
        // R3: each output is the wrapped sum of the pair taken four clocks earlier
        p_sum_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
            vld_o |-> (sum_o == W'($past(a_i, 4) + $past(b_i, 4))));
    end

endmodule

// File: rtl/vsk_sched.sv
module vsk_sched
    import vsk_pkg::*;
#(
    parameter int NB     = 8,
    parameter int OFF_B  = 2,
    parameter int OFF_C  = 4,
    parameter int LAT    = 2,
    parameter int STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  clash_i,
    output logic [NB-1:0]         rd_req_o,
    output logic [NB-1:0]         rd_selb_o,
    output logic [NB-1:0]         wr_req_o,
    output logic                  add_en_o,
    output logic [$clog2(NB)-1:0] a_bank_o,
    output logic [$clog2(NB)-1:0] b_bank_o,
    output logic                  done_o,
    output logic                  err_o
);

    localparam int IW   = $clog2(NB);
    localparam int WR0  = LAT + STAGES;
    localparam int LAST = WR0 + NB + LAT - 2;
    localparam int CW   = $clog2(LAST + 2);

    sched_state_e  state, nxt;
    logic [CW-1:0] cnt;
    logic          err;
    logic          accept;

    logic          rd_en, wr_en;
    logic [IW-1:0] rd_idx, rd_b, wr_idx, wr_c, add_idx;

    assign accept = start_i && (state != ST_RUN);

    // state register, timetable counter and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_RUN && cnt != CW'(LAST)) ? cnt + 1'b1 : '0;
            if (accept) begin
                err <= 1'b0;
            end else if (clash_i) begin
                err <= 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start_i) nxt = ST_RUN;
            ST_RUN:  if (cnt == CW'(LAST)) nxt = ST_DONE;
            ST_DONE: if (start_i) nxt = ST_RUN;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the timetable position
    always_comb begin
        rd_en    = (state == ST_RUN) && (cnt < CW'(NB));
        add_en_o = (state == ST_RUN) && (cnt >= CW'(LAT)) && (cnt < CW'(LAT + NB));
        wr_en    = (state == ST_RUN) && (cnt >= CW'(WR0)) && (cnt < CW'(WR0 + NB));
        rd_idx   = IW'(cnt);
        add_idx  = IW'(cnt - CW'(LAT));
        wr_idx   = IW'(cnt - CW'(WR0));
        rd_b     = rd_idx + IW'(OFF_B);
        wr_c     = wr_idx + IW'(OFF_C);
        a_bank_o = add_idx;
        b_bank_o = add_idx + IW'(OFF_B);
        for (int m = 0; m < NB; m++) begin
            rd_req_o[m]  = rd_en && ((IW'(m) == rd_idx) || (IW'(m) == rd_b));
            rd_selb_o[m] = (IW'(m) == rd_b);
            wr_req_o[m]  = wr_en && (IW'(m) == wr_c);
        end
        done_o = (state == ST_DONE);
        err_o  = err;
    end

    // R6: a running timetable advances one step per clock whatever start does
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt != CW'(LAST)) |=>
            (state == ST_RUN && (cnt - $past(cnt)) == CW'(1)));

    // R7: done holds until a start arrives
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R2: reads come in A/B pairs, never one alone
    p_read_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rd_req_o) == 0) || ($countones(rd_req_o) == 2));

    // R2: at most one module is written per clock
    p_write_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_req_o));

endmodule

// File: rtl/skew_vec_adder.sv
module skew_vec_adder #(
    parameter int W      = 32,
    parameter int NB     = 8,
    parameter int OFF_B  = 2,
    parameter int OFF_C  = 4,
    parameter int LAT    = 2,
    parameter int STAGES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NB*W-1:0] img_a_i,
    input  logic [NB*W-1:0] img_b_i,
    output logic [NB*W-1:0] res_o,
    output logic          done_o,
    output logic          clash_o
);

    localparam int IW = $clog2(NB);

    logic [NB-1:0] rd_req, rd_selb, wr_req, clash_v;
    logic [W-1:0]  rd_data [NB];
    logic          add_en, sum_vld;
    logic [IW-1:0] a_bank, b_bank;
    logic [W-1:0]  sum;

    vsk_sched #(
        .NB(NB), .OFF_B(OFF_B), .OFF_C(OFF_C), .LAT(LAT), .STAGES(STAGES)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .clash_i   (|clash_v),
        .rd_req_o  (rd_req),
        .rd_selb_o (rd_selb),
        .wr_req_o  (wr_req),
        .add_en_o  (add_en),
        .a_bank_o  (a_bank),
        .b_bank_o  (b_bank),
        .done_o    (done_o),
        .err_o     (clash_o)
    );

    for (genvar m = 0; m < NB; m++) begin : g_bank
        vsk_bank #(.W(W), .LAT(LAT)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_req_i  (rd_req[m]),
            .rd_selb_i (rd_selb[m]),
            .wr_req_i  (wr_req[m]),
            .wr_data_i (sum),
            .img_a_i   (img_a_i[m*W +: W]),
            .img_b_i   (img_b_i[m*W +: W]),
            .rd_data_o (rd_data[m]),
            .res_o     (res_o[m*W +: W]),
            .clash_o   (clash_v[m])
        );
    end

    vsk_padd #(.W(W), .STAGES(STAGES)) u_add (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (add_en),
        .a_i   (rd_data[a_bank]),
        .b_i   (rd_data[b_bank]),
        .vld_o (sum_vld),
        .sum_o (sum)
    );

    // R4: every write carries a sum that has just left the adder
    p_write_has_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_req) |-> sum_vld);

    // R5: a finished run reports no clash
    p_clean_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !clash_o);

endmodule

// File: tb/test_skew_vec_adder.sv
module test_skew_vec_adder;

    localparam int W  = 32;
    localparam int NB = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NB*W-1:0] img_a = '0;
    logic [NB*W-1:0] img_b = '0;
    logic [NB*W-1:0] res;
    logic            done;
    logic            clash;

    int nchk = 0;
    int nfail = 0;

    logic [W-1:0] va [NB];
    logic [W-1:0] vb [NB];
    logic [W-1:0] ec [NB];

    // rows: base A, step A, base B, step B
    localparam logic [W-1:0] TBL [5][4] = '{
        '{32'h0000_0001, 32'h0000_0001, 32'h0000_0064, 32'h0000_000A},
        '{32'hFFFF_FFF0, 32'h0000_0003, 32'h0000_0020, 32'h0000_0001},
        '{32'h8000_0000, 32'h1000_0000, 32'h8000_0000, 32'h0000_0000},
        '{32'h00FF_FFFF, 32'h0100_0000, 32'h0000_0001, 32'h0000_0000},
        '{32'h1234_5678, 32'h0101_0101, 32'hEDCB_A987, 32'hFEFE_FEFF}
    };

    always #4 clk = ~clk;

    skew_vec_adder i_skew_vec_adder (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .img_a_i (img_a),
        .img_b_i (img_b),
        .res_o   (res),
        .done_o  (done),
        .clash_o (clash)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_img();
        for (int i = 0; i < NB; i++) begin
            img_a[i*W +: W]              = va[i];
            img_b[((i + 2) % NB)*W +: W] = vb[i];
            ec[i]                        = va[i] + vb[i];
        end
    endtask

    function automatic logic [W-1:0] cword(input int i);
        return res[((i + 4) % NB)*W +: W];
    endfunction

    task automatic check_all(input string tag);
        for (int i = 0; i < NB; i++) begin
            chk(tag, cword(i), ec[i]);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // leaves the bench in the middle of clock 0 of the run
    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        logic [W-1:0] prev0;
        logic [W-1:0] oldA0;

        // R1: reset state
        step(3);
        chk("R1 done", W'(done), '0);
        chk("R1 clash", W'(clash), '0);
        for (int m = 0; m < NB; m++) begin
            chk("R1 res", res[m*W +: W], '0);
        end
        rst_n = 1'b1;
        step(2);

        // table of vectors: R2 R3 R4 R5 R8
        for (int r = 0; r < 5; r++) begin
            prev0 = cword(0);
            for (int i = 0; i < NB; i++) begin
                va[i] = TBL[r][0] + TBL[r][1] * W'(i);
                vb[i] = TBL[r][2] + TBL[r][3] * W'(i);
            end
            load_img();
            pulse_start();
            chk("R7 done low in clock 0", W'(done), '0);
            if (r == 1) begin
                step(7);
                chk("R4 C0 not yet in clock 7", cword(0), prev0);
                step(1);
                chk("R4 C0 in clock 8", cword(0), ec[0]);
                step(6);
            end else begin
                step(14);
            end
            chk("R4 done low in clock 14", W'(done), '0);
            step(1);
            chk("R4 done in clock 15", W'(done), 32'd1);
            chk("R5 clash", W'(clash), '0);
            check_all("R2 R3 R8 results");
        end

        // R6: start pulse in the middle of a run
        for (int i = 0; i < NB; i++) begin
            va[i] = 32'hA5A5_0000 + W'(i * 7);
            vb[i] = 32'h0000_5A5A - W'(i * 3);
        end
        load_img();
        pulse_start();
        step(4);
        start = 1'b1;
        step(1);
        start = 1'b0;
        step(9);
        chk("R6 done low in clock 14", W'(done), '0);
        step(1);
        chk("R6 done in clock 15", W'(done), 32'd1);
        check_all("R6 results");

        // R7: done held in ST_DONE
        step(10);
        chk("R7 done held", W'(done), 32'd1);

        // R9: image rewrite after A0 capture, before A7 capture
        for (int i = 0; i < NB; i++) begin
            va[i] = 32'h0000_1000 + W'(i);
            vb[i] = 32'h0000_0200 + W'(i * 16);
        end
        load_img();
        oldA0 = va[0];
        pulse_start();
        step(2);
        va[0] = 32'h7777_0000;
        va[7] = 32'h3333_0000;
        load_img();
        ec[0] = oldA0 + vb[0];
        step(12);
        chk("R7 done low during run", W'(done), '0);
        step(1);
        chk("R9 C0 keeps captured operand", cword(0), ec[0]);
        chk("R9 C7 takes new operand", cword(7), ec[7]);
        check_all("R9 results");
        chk("R5 clash after run", W'(clash), '0);

        finish_up();
    end

endmodule